// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces the horizontal sync, vertical sync and data-enable strobes of a progressive raster display, together with the pixel coordinate inside the visible window and one-cycle start-of-frame and end-of-frame pulses. Software describes each axis by a total count, an active window given as absolute start and end counts, and a sync width. All of them are counted from the first clock of sync. The active start is the sync width plus the back porch. The active end is the active start plus the visible size. The total is the active end plus the front porch.

Software starts the raster through a control register. A stop can be requested without tearing the picture: the current frame runs to its last pixel, the raster halts, and a sticky flag tells software that the stop has completed. Start-of-frame and end-of-frame also leave sticky flags, which software clears with a masked write. The geometry registers are copied into a working set only at a frame boundary, so software may reprogram them while the raster is running.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, hsync, vsync, de, sof and eof are low, px_x and px_y are 0, every register reads 0 and the raster is stopped.
- R2: Writing the control register (word address 0) with bit 3 (enable) set and bit 4 (stop request) clear starts a stopped raster with both counters at 0 on the next clock. sof is high in that cycle.
- R3: The horizontal count runs from 0 to h_total-1. On wrap the vertical count advances, and it runs from 0 to v_total-1. The totals live in word address 1: horizontal in [31:16], vertical in [15:0].
- R4: hsync is high while the horizontal count is below the width held in word address 4 [15:0]. vsync is high while the vertical count is below the width held in word address 5 [15:0].
- R5: de is high exactly when the horizontal count lies in [start, end) of word address 2 and the vertical count lies in [start, end) of word address 3. In both registers start is in [31:16] and end is in [15:0]. During de, px_x = horizontal count - horizontal start and px_y = vertical count - vertical start. Outside de both are 0.
- R6: eof is high for one cycle at the last pixel of a frame (horizontal count h_total-1, vertical count v_total-1). sof is high at counts (0,0).
- R7: The raster samples the geometry registers only when it starts and when a frame wraps. A write during a frame takes effect from the next frame.
- R8: A stop request (bit 4) while running lets the current frame finish. After the eof cycle the raster halts, all outputs go low, and status bit 0 (stop done) is set.
- R9: The status register (word address 6) holds sticky flags: bit 0 stop done, bit 4 start of frame, bit 5 end of frame. A write keeps only the flags whose bits are 1 in the written data, so writing 0 clears all of them. An event in the same cycle as the write sets its flag anyway.
- R10: Clearing the enable bit while running halts the raster at once, with outputs low and the stop-done flag left unchanged.
- R11: Every register reads back on rd_data at its word address. Control reads back with its two bits in place, and bits not listed above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register word address for writes |
| wr_data | input | 32 | register write data |
| rd_addr | input | 3 | register word address for reads |
| rd_data | output | 32 | read data for rd_addr (combinational) |
| hsync | output | 1 | horizontal sync, active high |
| vsync | output | 1 | vertical sync, active high |
| de | output | 1 | data enable (visible pixel) |
| px_x | output | 16 | column inside the active window |
| px_y | output | 16 | row inside the active window |
| sof | output | 1 | first pixel of a frame |
| eof | output | 1 | last pixel of a frame |

## Verification
The hardest situations to reach are the frame boundary cases: a geometry write in the middle of a frame that must not show until the wrap, and a stop request that must be held off until the very last pixel. The bench reaches them by issuing these writes at arbitrary points of a small frame. A cycle-accurate reference model of the requirements runs beside the design and predicts every output and the status word each cycle. A second geometry with zero sync width, a window that starts at count 0 and a sync longer than the frame exercises the window edges.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  parameter int FIELD_W = 16;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_TOTAL = 3'd1,
    A_HWIN  = 3'd2,
    A_VWIN  = 3'd3,
    A_HSW   = 3'd4,
    A_VSW   = 3'd5,
    A_STAT  = 3'd6
  } reg_addr_e;

  localparam int BIT_EN   = 3;
  localparam int BIT_STOP = 4;
  localparam int BIT_DONE = 0;
  localparam int BIT_SOF  = 4;
  localparam int BIT_EOF  = 5;

  typedef struct packed {
    logic [FIELD_W-1:0] total;
    logic [FIELD_W-1:0] win_start;
    logic [FIELD_W-1:0] win_end;
    logic [FIELD_W-1:0] sync_w;
  } axis_t;

  typedef struct packed {
    axis_t h;
    axis_t v;
  } geom_t;

  typedef struct packed {
    logic eof_f;
    logic sof_f;
    logic done_f;
  } flags_t;

  function automatic logic in_span(input logic [FIELD_W-1:0] c,
                                   input logic [FIELD_W-1:0] lo,
                                   input logic [FIELD_W-1:0] hi);
    return (c >= lo) && (c < hi);
  endfunction

  function automatic logic at_last(input logic [FIELD_W-1:0] c,
                                   input logic [FIELD_W-1:0] tot);
    return c == (tot - 1'b1);
  endfunction

  function automatic flags_t flags_next(input flags_t cur, input logic wr,
                                        input logic [31:0] wd, input logic sof_e,
                                        input logic eof_e, input logic done_e);
    flags_t n;
    n = cur;
    if (wr) begin
      n.done_f = cur.done_f & wd[BIT_DONE];
      n.sof_f  = cur.sof_f  & wd[BIT_SOF];
      n.eof_f  = cur.eof_f  & wd[BIT_EOF];
    end
    n.done_f = n.done_f | done_e;
    n.sof_f  = n.sof_f  | sof_e;
    n.eof_f  = n.eof_f  | eof_e;
    return n;
  endfunction
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sof_evt,
  input  logic              eof_evt,
  input  logic              done_evt,
  output logic              ctrl_en,
  output logic              ctrl_stop,
  output geom_t             geom_live
);
  localparam int HI = DATA_W - 1;
  localparam int LO_TOP = DATA_W / 2;

  flags_t flags_q;
  logic   stat_wr;

  assign stat_wr = wr_en && (wr_addr == ADDR_W'(A_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_stop <= 1'b0;
      geom_live <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(A_CTRL): begin
          ctrl_en   <= wr_data[BIT_EN];
          ctrl_stop <= wr_data[BIT_STOP];
        end
        ADDR_W'(A_TOTAL): begin
          geom_live.h.total <= wr_data[HI:LO_TOP];
          geom_live.v.total <= wr_data[LO_TOP-1:0];
        end
        ADDR_W'(A_HWIN): begin
          geom_live.h.win_start <= wr_data[HI:LO_TOP];
          geom_live.h.win_end   <= wr_data[LO_TOP-1:0];
        end
        ADDR_W'(A_VWIN): begin
          geom_live.v.win_start <= wr_data[HI:LO_TOP];
          geom_live.v.win_end   <= wr_data[LO_TOP-1:0];
        end
        ADDR_W'(A_HSW): geom_live.h.sync_w <= wr_data[LO_TOP-1:0];
        ADDR_W'(A_VSW): geom_live.v.sync_w <= wr_data[LO_TOP-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_next(flags_q, stat_wr, wr_data, sof_evt, eof_evt, done_evt);
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(A_CTRL): begin
        rd_data[BIT_EN]   = ctrl_en;
        rd_data[BIT_STOP] = ctrl_stop;
      end
      ADDR_W'(A_TOTAL): rd_data = {geom_live.h.total, geom_live.v.total};
      ADDR_W'(A_HWIN):  rd_data = {geom_live.h.win_start, geom_live.h.win_end};
      ADDR_W'(A_VWIN):  rd_data = {geom_live.v.win_start, geom_live.v.win_end};
      ADDR_W'(A_HSW):   rd_data[LO_TOP-1:0] = geom_live.h.sync_w;
      ADDR_W'(A_VSW):   rd_data[LO_TOP-1:0] = geom_live.v.sync_w;
      ADDR_W'(A_STAT): begin
        rd_data[BIT_DONE] = flags_q.done_f;
        rd_data[BIT_SOF]  = flags_q.sof_f;
        rd_data[BIT_EOF]  = flags_q.eof_f;
      end
      default: ;
    endcase
  end

  // R8: a completed stop is remembered
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> flags_q.done_f);

  // R9: a zero write with no event in flight empties the flags
  p_flags_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wr_data == '0 && !sof_evt && !eof_evt && !done_evt) |=> (flags_q == '0));
endmodule

// File: rtl/dtg_raster.sv
module dtg_raster
  import dtg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_en,
  input  logic               ctrl_stop,
  input  geom_t              geom_live,
  output geom_t              geom_sh,
  output logic               running,
  output logic [FIELD_W-1:0] hcnt,
  output logic [FIELD_W-1:0] vcnt,
  output logic               line_end,
  output logic               frame_end,
  output logic               done_evt
);
  logic start_evt;

  assign start_evt = !running && ctrl_en && !ctrl_stop;
  assign line_end  = running && at_last(hcnt, geom_sh.h.total);
  assign frame_end = line_end && at_last(vcnt, geom_sh.v.total);
  assign done_evt  = frame_end && ctrl_en && ctrl_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
      geom_sh <= '0;
    end else if (start_evt) begin
      running <= 1'b1;
      hcnt    <= '0;
      vcnt    <= '0;
      geom_sh <= geom_live;
    end else if (running) begin
      if (!ctrl_en) begin
        running <= 1'b0;
        hcnt    <= '0;
        vcnt    <= '0;
      end else if (line_end) begin
        hcnt <= '0;
        if (frame_end) begin
          vcnt <= '0;
          if (ctrl_stop) running <= 1'b0;
          else           geom_sh <= geom_live;
        end else begin
          vcnt <= vcnt + 1'b1;
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  // R3: horizontal count advances by one inside a line
  p_h_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && ctrl_en && !line_end) |=> (hcnt == $past(hcnt) + 1'b1));

  // R3: horizontal count stays below the working total
  p_h_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && geom_sh.h.total != '0) |-> (hcnt < geom_sh.h.total));

  // R7: working geometry only changes at a frame wrap
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !frame_end) |=> $stable(geom_sh));
endmodule

// File: rtl/dtg_axis_dec.sv
module dtg_axis_dec
  import dtg_pkg::*;
(
  input  logic               running,
  input  logic [FIELD_W-1:0] cnt,
  input  axis_t              ax,
  output logic               sync_o,
  output logic               act_o,
  output logic [FIELD_W-1:0] off_o
);
  assign sync_o = running && (cnt < ax.sync_w);
  assign act_o  = running && in_span(cnt, ax.win_start, ax.win_end);
  assign off_o  = cnt - ax.win_start;
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [15:0]       px_x,
  output logic [15:0]       px_y,
  output logic              sof,
  output logic              eof
);
  localparam int N_AXES = 2;

  geom_t              geom_live, geom_sh;
  logic               ctrl_en, ctrl_stop;
  logic               running, line_end, frame_end, done_evt;
  logic [FIELD_W-1:0] hcnt, vcnt;
  logic [FIELD_W-1:0] ax_cnt  [N_AXES];
  axis_t              ax_geom [N_AXES];
  logic               ax_sync [N_AXES];
  logic               ax_act  [N_AXES];
  logic [FIELD_W-1:0] ax_off  [N_AXES];

  dtg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sof_evt(sof), .eof_evt(eof),
    .done_evt(done_evt), .ctrl_en(ctrl_en), .ctrl_stop(ctrl_stop), .geom_live(geom_live)
  );

  dtg_raster u_raster (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .ctrl_stop(ctrl_stop),
    .geom_live(geom_live), .geom_sh(geom_sh), .running(running),
    .hcnt(hcnt), .vcnt(vcnt), .line_end(line_end), .frame_end(frame_end),
    .done_evt(done_evt)
  );

  assign ax_cnt[0]  = hcnt;
  assign ax_cnt[1]  = vcnt;
  assign ax_geom[0] = geom_sh.h;
  assign ax_geom[1] = geom_sh.v;

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    dtg_axis_dec u_dec (
      .running(running), .cnt(ax_cnt[a]), .ax(ax_geom[a]),
      .sync_o(ax_sync[a]), .act_o(ax_act[a]), .off_o(ax_off[a])
    );
  end

  assign hsync = ax_sync[0];
  assign vsync = ax_sync[1];
  assign de    = ax_act[0] && ax_act[1];
  assign px_x  = de ? ax_off[0] : '0;
  assign px_y  = de ? ax_off[1] : '0;
  assign sof   = running && (hcnt == '0) && (vcnt == '0);
  assign eof   = frame_end;

  // R2: the first running cycle is a frame start
  p_sof_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> sof);

  // R8: a graceful stop happens only on the last pixel
  p_stop_on_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> eof);

  // R8: after a graceful stop the raster is idle and quiet
  p_idle_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!running && !de && !hsync));
endmodule

// File: tb/disp_timing_gen_test.sv
`timescale 1ns/1ps
module disp_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd6;
  logic [31:0] rd_data;
  logic        hsync, vsync, de, sof, eof;
  logic [15:0] px_x, px_y;

  int checks = 0;
  int failures = 0;
  bit done_run = 0;

  always #2.5 clk = ~clk;

  disp_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hsync(hsync), .vsync(vsync), .de(de),
    .px_x(px_x), .px_y(px_y), .sof(sof), .eof(eof)
  );

  typedef struct {
    bit hs, vs, de, sof, eof;
    int x, y;
    int stat;
  } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model state (from the requirements)
  int r_en, r_stop, r_ht, r_vt, r_hs, r_he, r_vs, r_ve, r_hw, r_vw;
  int s_ht, s_vt, s_hs, s_he, s_vs, s_ve, s_hw, s_vw;
  int m_run, m_h, m_v, m_stat;
  int sof_p, eof_p, done_p;
  exp_t e;

  task automatic load_shadow();
    s_ht = r_ht; s_vt = r_vt; s_hs = r_hs; s_he = r_he;
    s_vs = r_vs; s_ve = r_ve; s_hw = r_hw; s_vw = r_vw;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      {r_en, r_stop, r_ht, r_vt, r_hs, r_he, r_vs, r_ve, r_hw, r_vw} = '0;
      {s_ht, s_vt, s_hs, s_he, s_vs, s_ve, s_hw, s_vw} = '0;
      m_run = 0; m_h = 0; m_v = 0; m_stat = 0;
      q.delete();
    end else begin
      sof_p  = (m_run != 0 && m_h == 0 && m_v == 0) ? 1 : 0;
      eof_p  = (m_run != 0 && m_h == s_ht - 1 && m_v == s_vt - 1) ? 1 : 0;
      done_p = 0;
      if (m_run == 0) begin
        if (r_en != 0 && r_stop == 0) begin
          m_run = 1; m_h = 0; m_v = 0; load_shadow();
        end
      end else if (r_en == 0) begin
        m_run = 0; m_h = 0; m_v = 0;
      end else if (m_h == s_ht - 1) begin
        m_h = 0;
        if (m_v == s_vt - 1) begin
          m_v = 0;
          if (r_stop != 0) begin m_run = 0; done_p = 1; end
          else load_shadow();
        end else m_v = m_v + 1;
      end else m_h = m_h + 1;
      if (wr_en && wr_addr == 3'd6) m_stat = m_stat & int'(wr_data) & 32'h31;
      m_stat = m_stat | (sof_p << 4) | (eof_p << 5) | done_p;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin r_en = int'(wr_data[3]); r_stop = int'(wr_data[4]); end
          3'd1: begin r_ht = int'(wr_data[31:16]); r_vt = int'(wr_data[15:0]); end
          3'd2: begin r_hs = int'(wr_data[31:16]); r_he = int'(wr_data[15:0]); end
          3'd3: begin r_vs = int'(wr_data[31:16]); r_ve = int'(wr_data[15:0]); end
          3'd4: r_hw = int'(wr_data[15:0]);
          3'd5: r_vw = int'(wr_data[15:0]);
          default: ;
        endcase
      end
      e.hs  = (m_run != 0 && m_h < s_hw);
      e.vs  = (m_run != 0 && m_v < s_vw);
      e.de  = (m_run != 0 && m_h >= s_hs && m_h < s_he && m_v >= s_vs && m_v < s_ve);
      e.x   = e.de ? m_h - s_hs : 0;
      e.y   = e.de ? m_v - s_vs : 0;
      e.sof = (m_run != 0 && m_h == 0 && m_v == 0);
      e.eof = (m_run != 0 && m_h == s_ht - 1 && m_v == s_vt - 1);
      e.stat = m_stat;
      q.push_back(e);
    end
  end

  // monitor: compare every cycle away from the active edge
  exp_t g;
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      g = q.pop_front();
      chk(hsync == g.hs, "R4", "hsync", hsync, g.hs);
      chk(vsync == g.vs, "R4", "vsync", vsync, g.vs);
      chk(de == g.de, "R5 R7 R3", "de", de, g.de);
      chk(px_x == 16'(g.x), "R5", "px_x", px_x, g.x);
      chk(px_y == 16'(g.y), "R5", "px_y", px_y, g.y);
      chk(sof == g.sof, "R2 R6", "sof", sof, g.sof);
      chk(eof == g.eof, "R6 R8", "eof", eof, g.eof);
      if (rd_addr == 3'd6)
        chk(rd_data == 32'(g.stat), "R9 R8 R10", "status", rd_data, g.stat);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    #1;
    rd_addr = a;
    #0.5;
    chk(rd_data == exp, req, "readback", rd_data, exp);
    rd_addr = 3'd6;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({hsync, vsync, de, sof, eof} == 5'b0, "R1", "strobes in reset", {hsync, vsync, de, sof, eof}, 0);
    chk(px_x == 0 && px_y == 0, "R1", "coords in reset", {px_x, px_y}, 0);
    chk(rd_data == 0, "R1", "status in reset", rd_data, 0);
    rst_n = 1'b1;
    idle(2);
    rd_check(3'd1, 32'h0, "R1");

    // geometry A: 12 x 6 frame
    wr(3'd1, {16'd12, 16'd6});
    wr(3'd2, {16'd3, 16'd9});
    wr(3'd3, {16'd2, 16'd5});
    wr(3'd4, 32'd2);
    wr(3'd5, 32'd1);
    rd_check(3'd1, 32'h000C_0006, "R11");
    rd_check(3'd2, 32'h0003_0009, "R11");
    rd_check(3'd4, 32'h0000_0002, "R11");

    wr(3'd0, 32'h8);            // R2 start
    rd_check(3'd0, 32'h8, "R11");
    idle(150);                  // R3 R4 R5 R6 over two frames
    wr(3'd6, 32'h10);           // R9 masked clear keeps only start flag
    idle(10);
    wr(3'd6, 32'h0);            // R9 clear all
    idle(5);
    wr(3'd2, {16'd4, 16'd10});  // R7 mid-frame change
    wr(3'd5, 32'd2);
    idle(150);

    wr(3'd0, 32'h18);           // R8 graceful stop mid frame
    idle(160);
    chk(rd_data[0] == 1'b1, "R8", "stop done flag", rd_data[0], 1);
    chk({hsync, vsync, de} == 3'b0, "R8", "quiet after stop", {hsync, vsync, de}, 0);

    wr(3'd6, 32'h0);
    wr(3'd0, 32'h8);
    idle(40);
    wr(3'd0, 32'h0);            // R10 immediate halt
    idle(80);
    chk(rd_data[0] == 1'b0, "R10", "no stop done flag", rd_data[0], 0);
    chk({hsync, vsync, de, sof, eof} == 5'b0, "R10", "quiet after halt", {hsync, vsync, de, sof, eof}, 0);

    // geometry B: window from count 0, no hsync, vsync longer than frame
    wr(3'd1, {16'd8, 16'd4});
    wr(3'd2, {16'd0, 16'd8});
    wr(3'd3, {16'd0, 16'd4});
    wr(3'd4, 32'd0);
    wr(3'd5, 32'd9);
    wr(3'd6, 32'h0);
    wr(3'd0, 32'h8);
    idle(100);
    wr(3'd0, 32'h18);
    idle(60);
    chk(rd_data[0] == 1'b1, "R8", "stop done flag geometry B", rd_data[0], 1);
    idle(3);
    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done_run) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule